// File: doc/BRIEF.md
# Truncatable Read Burst Output Sequencer

This block models the device side of a double-data-rate read path. A read command captures a bank and a starting column. After a configured CAS latency, the block streams a burst of data words, two words per clock. A precharge aimed at the bank of the running burst may cut the stream short. The cut does not take effect at once: words keep flowing for exactly the CAS latency after the precharge edge, and then the data lanes go idle and the output enable drops.

There is no storage array. Each word comes from a fixed pattern built from the bank, the column and the beat number, so the stream can be predicted outside the block. Burst length and CAS latency are latched while reset is held, which mirrors a mode setting fixed before operation begins. Strobe and analog timing are not modelled. The rising-edge and falling-edge words of each clock appear side by side on two lanes.

Top module: `rd_burst_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, both data lanes read zero and the strobe enable and output enable are low.
- R2: The burst setting (`cfg_bl`: 0 gives 2 words, 1 gives 4 words, 2 or 3 gives 8 words) and the latency setting (`cfg_cl`: 0 gives 2 cycles, 1 gives 3 cycles) are captured only while reset is high. Later changes on these inputs have no effect until the next reset.
- R3: If READ (`cmd`=1) is sampled at edge k, word pair i (counting from 0) is presented in the cycle after edge k+CL+i. `dq_rise` carries beat 2i and `dq_fall` carries beat 2i+1.
- R4: The word for beat b is the read bank in the top BANK_W bits and (column + b) modulo 2^(DW-BANK_W) in the low bits.
- R5: A burst that is not interrupted presents BL/2 consecutive pairs, and then the outputs return to idle.
- R6: A PRECHARGE (`cmd`=2) to the burst's bank, sampled at edge p with p ≥ k+1, limits the burst to min(BL/2, p-k) pairs. The lanes go idle from edge p+CL onward.
- R7: A same-bank PRECHARGE sampled at edge k+BL/2, which is CL cycles before the natural end, removes no data.
- R8: A PRECHARGE to any other bank leaves a running burst unchanged, and a PRECHARGE while no burst is active produces no output.
- R9: `dq_strobe_en` and `dq_oe` are high exactly in the cycles that carry burst words. In all other cycles both lanes read zero.
- R10: A READ sampled during a burst ends the old burst at that edge, and a fresh burst starts by the timing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; settings latched while high |
| cmd | input | 2 | Decoded command: 0 NOP, 1 READ, 2 PRECHARGE |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_col | input | COL_W | Start column for READ |
| cfg_bl | input | 2 | Burst length setting |
| cfg_cl | input | 1 | CAS latency setting |
| dq_rise | output | DW | Word for the rising half of the clock |
| dq_fall | output | DW | Word for the falling half of the clock |
| dq_strobe_en | output | 1 | High while burst words are presented |
| dq_oe | output | 1 | Tristate enable for the data lanes |

## Verification
After a READ sampled at edge k, the scoreboard expects pair i at the cycle count k+CL+i. After a same-bank precharge at edge p, it expects nothing from edge p+CL onward. The driver computes these cycle stamps from the requirements when it issues the commands. The monitor samples on the falling clock edge and compares each presented pair against the stamp at the head of the queue. An expected pair whose cycle has passed without output counts as a miss. Any word presented with an empty queue counts as an unexpected output, which is how ignored precharges and stale bursts are caught.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_READ = 2'd1,
        CMD_PRE  = 2'd2
    } cmd_e;

    localparam int PAIR_W = 3;   // holds up to 4 pairs
    localparam int AGE_W  = 4;   // holds CL max + pairs max

    typedef struct packed {
        logic [PAIR_W-1:0] pairs;
        logic [1:0]        cl;
    } cfg_t;

    function automatic logic [PAIR_W-1:0] decode_pairs(input logic [1:0] code);
        case (code)
            2'd0:    return PAIR_W'(1);
            2'd1:    return PAIR_W'(2);
            default: return PAIR_W'(4);
        endcase
    endfunction

    function automatic logic [1:0] decode_cl(input logic code);
        return code ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/rbs_cfg.sv
module rbs_cfg
    import rbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_bl,
    input  logic       cfg_cl,
    output cfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.pairs <= decode_pairs(cfg_bl);
            cfg.cl    <= decode_cl(cfg_cl);
        end
    end
endmodule

// File: rtl/rbs_track.sv
module rbs_track
    import rbs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  cfg_t              cfg,
    output logic              emit,
    output logic [PAIR_W-1:0] pair_idx,
    output logic [BANK_W-1:0] burst_bank,
    output logic [COL_W-1:0]  burst_col
);
    logic              active;
    logic [AGE_W-1:0]  age;
    logic [AGE_W-1:0]  age_p1;
    logic [AGE_W-1:0]  cl_m1;
    logic [PAIR_W-1:0] limit;
    logic [PAIR_W-1:0] lim_next;
    logic              hit_pre;

    always_comb begin
        cl_m1    = AGE_W'(cfg.cl) - AGE_W'(1);
        age_p1   = age + AGE_W'(1);
        emit     = active && (age >= cl_m1);
        pair_idx = PAIR_W'(age - cl_m1);
        hit_pre  = (cmd == CMD_PRE) && (cmd_bank == burst_bank);
        lim_next = (hit_pre && (age_p1 < AGE_W'(limit))) ? PAIR_W'(age_p1) : limit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            age        <= '0;
            limit      <= '0;
            burst_bank <= '0;
            burst_col  <= '0;
        end else if (cmd == CMD_READ) begin
            active     <= 1'b1;
            age        <= '0;
            limit      <= cfg.pairs;
            burst_bank <= cmd_bank;
            burst_col  <= cmd_col;
        end else if (active) begin
            age   <= age_p1;
            limit <= lim_next;
            if (emit && (pair_idx == lim_next - PAIR_W'(1)))
                active <= 1'b0;
        end
    end
endmodule

// File: rtl/rbs_drive.sv
module rbs_drive
    import rbs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAIR_W-1:0] pair_idx,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    output logic [DW-1:0]     lane_rise,
    output logic [DW-1:0]     lane_fall,
    output logic              valid
);
    localparam int LW = DW - BANK_W;
    localparam int LANES = 2;

    logic [DW-1:0] word [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PAIR_W:0] beat;
        always_comb begin
            beat    = {pair_idx, 1'(g)};
            word[g] = {bank, LW'(col) + LW'(beat)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !load) begin
            valid     <= 1'b0;
            lane_rise <= '0;
            lane_fall <= '0;
        end else begin
            valid     <= 1'b1;
            lane_rise <= word[0];
            lane_fall <= word[1];
        end
    end
endmodule

// File: rtl/rd_burst_seq.sv
module rd_burst_seq
    import rbs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [1:0]        cfg_bl,
    input  logic              cfg_cl,
    output logic [DW-1:0]     dq_rise,
    output logic [DW-1:0]     dq_fall,
    output logic              dq_strobe_en,
    output logic              dq_oe
);
    cfg_t              cfg_q;
    cmd_e              cmd_t;
    logic              emit;
    logic [PAIR_W-1:0] pair_idx;
    logic [BANK_W-1:0] burst_bank;
    logic [COL_W-1:0]  burst_col;
    logic              lane_valid;

    assign cmd_t = cmd_e'(cmd);

    rbs_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_bl (cfg_bl),
        .cfg_cl (cfg_cl),
        .cfg    (cfg_q)
    );

    rbs_track #(.BANK_W(BANK_W), .COL_W(COL_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd_t),
        .cmd_bank   (cmd_bank),
        .cmd_col    (cmd_col),
        .cfg        (cfg_q),
        .emit       (emit),
        .pair_idx   (pair_idx),
        .burst_bank (burst_bank),
        .burst_col  (burst_col)
    );

    rbs_drive #(.BANK_W(BANK_W), .COL_W(COL_W), .DW(DW)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .load      (emit && (cmd_t != CMD_READ)),
        .pair_idx  (pair_idx),
        .bank      (burst_bank),
        .col       (burst_col),
        .lane_rise (dq_rise),
        .lane_fall (dq_fall),
        .valid     (lane_valid)
    );

    assign dq_strobe_en = lane_valid;
    assign dq_oe        = lane_valid;
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker
    import rbs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int DW     = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cmd,
    input logic [DW-1:0] dq_rise,
    input logic [DW-1:0] dq_fall,
    input logic          dq_strobe_en,
    input cfg_t          cfg_q
);
    localparam int LW = DW - BANK_W;

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !dq_strobe_en |-> (dq_rise == '0 && dq_fall == '0));

    p_read_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'(CMD_READ)) |=> !dq_strobe_en);

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cfg_q));

    p_lane_pair_r4: assert property (@(posedge clk) disable iff (rst)
        dq_strobe_en |-> (dq_fall[LW-1:0] == dq_rise[LW-1:0] + LW'(1)
                          && dq_fall[DW-1:LW] == dq_rise[DW-1:LW]));

    p_beat_step_r3: assert property (@(posedge clk) disable iff (rst)
        (dq_strobe_en && $past(dq_strobe_en))
            |-> (dq_rise[LW-1:0] == $past(dq_rise[LW-1:0]) + LW'(2)));
endmodule

bind rd_burst_seq rbs_checker #(.BANK_W(BANK_W), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd          (cmd),
    .dq_rise      (dq_rise),
    .dq_fall      (dq_fall),
    .dq_strobe_en (dq_strobe_en),
    .cfg_q        (cfg_q)
);

// File: tb/tb_rd_burst_seq.sv
`timescale 1ns/1ps
module tb_rd_burst_seq;
    localparam int BANK_W = 2;
    localparam int COL_W  = 10;
    localparam int DW     = 16;
    localparam int LW     = DW - BANK_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cmd = 2'd0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic [1:0]        cfg_bl = 2'd2;
    logic              cfg_cl = 1'b1;
    logic [DW-1:0]     dq_rise, dq_fall;
    logic              dq_strobe_en, dq_oe;

    rd_burst_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .DW(DW)) dut (
        .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .cfg_bl(cfg_bl), .cfg_cl(cfg_cl), .dq_rise(dq_rise), .dq_fall(dq_fall),
        .dq_strobe_en(dq_strobe_en), .dq_oe(dq_oe)
    );

    always #4 clk = ~clk;

    typedef struct {
        int            cyc;
        logic [DW-1:0] r;
        logic [DW-1:0] f;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int cyc = 0;
    int total = 0;
    int bad = 0;
    int cur_pairs = 4;
    int cur_cl = 3;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] ref_word(int bank, int col, int beat);
        logic [LW-1:0] low;
        low = LW'(col + beat);
        return {BANK_W'(bank), low};
    endfunction

    task automatic check(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    // monitor: compare presented pairs against scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(dq_oe == dq_strobe_en, "R9", "oe vs strobe", DW'(dq_oe), DW'(dq_strobe_en));
            if (dq_strobe_en) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected word", dq_rise, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.cyc == cyc, e.tag, "pair cycle", DW'(cyc), DW'(e.cyc));
                    check(dq_rise == e.r, e.tag, "rise word", dq_rise, e.r);
                    check(dq_fall == e.f, e.tag, "fall word", dq_fall, e.f);
                end
            end else begin
                check(dq_rise == '0 && dq_fall == '0, "R9", "idle lanes", dq_rise | dq_fall, '0);
                if (exp_q.size() != 0 && exp_q[0].cyc <= cyc) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(0, e.tag, "missing pair", '0, e.r);
                end
            end
        end
    end

    task automatic do_reset(logic [1:0] bl, logic cl, int pairs, int clc);
        @(negedge clk);
        rst = 1'b1; cfg_bl = bl; cfg_cl = cl; cmd = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_pairs = pairs; cur_cl = clc;
        @(negedge clk);
        // R1: first cycle after reset release is idle
        check(dq_rise == '0 && dq_fall == '0 && !dq_strobe_en && !dq_oe,
              "R1", "post-reset outputs", dq_rise | dq_fall, '0);
    endtask

    // called at a negedge; pre_off=0 means no precharge
    task automatic run_read(int bank, int col, int pre_off, int pre_bank, string tag);
        int k, np;
        k = cyc + 1;
        np = cur_pairs;
        if (pre_off > 0 && pre_bank == bank && pre_off < np) np = pre_off;
        for (int i = 0; i < np; i++) begin
            exp_t e;
            e.cyc = k + cur_cl + i;
            e.r = ref_word(bank, col, 2 * i);
            e.f = ref_word(bank, col, 2 * i + 1);
            e.tag = tag;
            exp_q.push_back(e);
        end
        cmd = 2'd1; cmd_bank = BANK_W'(bank); cmd_col = COL_W'(col);
        @(negedge clk);
        cmd = 2'd0;
        if (pre_off > 0) begin
            for (int j = 1; j < pre_off; j++) @(negedge clk);
            cmd = 2'd2; cmd_bank = BANK_W'(pre_bank);
            @(negedge clk);
            cmd = 2'd0;
        end
        repeat (cur_cl + cur_pairs + 3) @(negedge clk);
        check(exp_q.size() == 0, tag, "burst drained", DW'(exp_q.size()), '0);
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // BL8 CL3
        do_reset(2'd2, 1'b1, 4, 3);
        run_read(1, 10'h020, 0, 0, "R3");                 // full burst, R3 R4 R5
        run_read(3, 10'h3FC, 0, 0, "R4");                 // column near top
        run_read(2, 10'h100, 1, 2, "R6");                 // earliest precharge: 1 pair
        run_read(2, 10'h140, 3, 2, "R6");                 // truncated to 3 pairs
        run_read(0, 10'h008, 4, 0, "R7");                 // CL before end: full
        run_read(1, 10'h050, 1, 3, "R8");                 // other bank: full
        // R8: precharge while idle produces nothing
        cmd = 2'd2; cmd_bank = 2'd1;
        @(negedge clk); cmd = 2'd0;
        repeat (6) @(negedge clk);
        check(!dq_strobe_en, "R8", "idle precharge", DW'(dq_strobe_en), '0);
        // R10: second READ two cycles later replaces the first
        begin
            int k2;
            cmd = 2'd1; cmd_bank = 2'd0; cmd_col = 10'h200;
            @(negedge clk); cmd = 2'd0;
            @(negedge clk);
        end
        run_read(2, 10'h011, 0, 0, "R10");
        // R2: settings ignored outside reset
        cfg_bl = 2'd0; cfg_cl = 1'b0;
        @(negedge clk);
        run_read(1, 10'h077, 0, 0, "R2");
        // BL4 CL2
        do_reset(2'd1, 1'b0, 2, 2);
        run_read(0, 10'h012, 0, 0, "R5");
        run_read(3, 10'h0A0, 1, 3, "R6");
        run_read(3, 10'h0B0, 2, 3, "R7");
        // BL2 CL3
        do_reset(2'd0, 1'b1, 1, 3);
        run_read(2, 10'h1FF, 0, 0, "R5");
        run_read(2, 10'h1F0, 1, 2, "R7");
        // BL8 (code 3) CL2
        do_reset(2'd3, 1'b0, 4, 2);
        run_read(1, 10'h300, 0, 0, "R2");
        run_read(1, 10'h310, 2, 1, "R6");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule